// File: doc/BRIEF.md
# Iterative Radix-4 Integer Divider with Leading-Zero Skip

This block divides one 32-bit integer by another and returns either the quotient or the remainder. It follows the integer divide rules of a 32-bit RISC-V core. The signed and unsigned variants are chosen per command, and so is which of the two results comes back. The work is iterative: two quotient bits are settled in every busy cycle.

Before the loop starts, the block looks at the top of the dividend magnitude. Every whole quarter-word (8 bits) that is entirely zero is shifted out without being iterated. Each skipped quarter saves four cycles.

A command is a valid/ready transfer that carries both operands and the two select bits. Only one operation is in flight at a time. The result is presented with a valid flag and stays put until the consumer takes it. A busy output tells the surrounding logic that the unit cannot take a new command.

Top module: `radix4_divider`

## Requirements
- R1: With `cmd_signed`=0, the result is the unsigned quotient a/b, or the unsigned remainder a mod b, of the 32-bit operands.
- R2: With `cmd_signed`=1, operands are two's complement. The quotient is truncated toward zero, and the remainder carries the sign of the dividend (or is zero).
- R3: A zero divisor gives a quotient of 0xFFFFFFFF and a remainder equal to the dividend. `res_valid` rises on the first clock edge after the accepting edge.
- R4: A signed divide of 0x80000000 by 0xFFFFFFFF gives a quotient of 0x80000000 and a remainder of 0. `res_valid` rises on the first clock edge after the accepting edge.
- R5: Counting the accepting edge, `res_valid` rises after 1 + 4*(4-z) rising edges. Here z is the number of all-zero bytes at the top of the dividend magnitude, with z < 4, and no R3/R4 case applies. A zero dividend (z = 4) takes 1 edge.
- R6: `cmd_ready` is high only when the unit is idle, and `busy` is its complement. A `cmd_valid` given while not ready is ignored and does not alter the result in progress.
- R7: `res_valid` and `res_data` hold steady until an edge with `res_ready` high. After that edge `res_valid` is low and `cmd_ready` is high.
- R8: After reset, `cmd_ready` is 1, `res_valid` is 0 and `busy` is 0.
- R9: `cmd_rem`=1 selects the remainder and `cmd_rem`=0 the quotient; the selection is captured with the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command taken when valid is also high |
| cmd_a | input | 32 | Dividend |
| cmd_b | input | 32 | Divisor |
| cmd_signed | input | 1 | 1: two's complement operands, 0: unsigned |
| cmd_rem | input | 1 | 1: return remainder, 0: return quotient |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 32 | Quotient or remainder |
| busy | output | 1 | Operation running or result waiting |

## Verification
Two functions can meet in the same accept cycle: the leading-zero scan and the divide-by-zero or overflow shortcut. The case is provoked with a small dividend (three zero top bytes) over a zero divisor, and with the most negative dividend over -1. It is judged by the returned value and by a latency of one edge rather than the skip-shortened count.

A second meeting happens while the result is held. A stalled consumer and a rejected command are present at once; the scoreboard confirms that the held data stays stable and that the rejected operands never change it.

// File: rtl/radix4_divider.sv
`timescale 1ns/1ps
module radix4_divider #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [XLEN-1:0] cmd_a,
  input  logic [XLEN-1:0] cmd_b,
  input  logic            cmd_signed,
  input  logic            cmd_rem,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [XLEN-1:0] res_data,
  output logic            busy
);
  localparam int NBLK  = 4;
  localparam int BLK   = XLEN / NBLK;
  localparam int CPB   = BLK / 2;
  localparam int ITERS = XLEN / 2;
  localparam int CW    = $clog2(ITERS + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_t;
  state_t state;

  logic [XLEN-1:0] quo_q, rem_q, div_q;
  logic [CW-1:0]   cnt_q;
  logic            negq_q, negr_q, sel_q;

  assign cmd_ready = (state == S_IDLE);
  assign busy      = !cmd_ready;
  assign res_valid = (state == S_DONE);

  wire accept = cmd_valid && cmd_ready;
  wire a_neg  = cmd_signed && cmd_a[XLEN-1];
  wire b_neg  = cmd_signed && cmd_b[XLEN-1];
  wire [XLEN-1:0] mag_a = a_neg ? -cmd_a : cmd_a;
  wire [XLEN-1:0] mag_b = b_neg ? -cmd_b : cmd_b;
  wire div0 = (cmd_b == '0);
  wire ovf  = cmd_signed && (cmd_a == {1'b1, {(XLEN-1){1'b0}}}) && (&cmd_b);

  logic [2:0] zblk;
  always_comb begin
    logic found;
    found = 1'b0;
    zblk  = '0;
    for (int i = NBLK-1; i >= 0; i--) begin
      if (!found && mag_a[i*BLK +: BLK] == '0) zblk = zblk + 3'd1;
      else found = 1'b1;
    end
  end

  function automatic logic [XLEN:0] step(input logic [XLEN-1:0] r, input logic b,
                                         input logic [XLEN-1:0] d);
    logic [XLEN:0] t, diff;
    t    = {r, b};
    diff = t - {1'b0, d};
    if (t >= {1'b0, d}) return {1'b1, diff[XLEN-1:0]};
    return {1'b0, t[XLEN-1:0]};
  endfunction

  logic [XLEN:0] s1, s2;
  assign s1 = step(rem_q, quo_q[XLEN-1], div_q);
  assign s2 = step(s1[XLEN-1:0], quo_q[XLEN-2], div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      quo_q  <= '0;
      rem_q  <= '0;
      div_q  <= '0;
      cnt_q  <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          sel_q  <= cmd_rem;
          div_q  <= mag_b;
          negq_q <= 1'b0;
          negr_q <= 1'b0;
          if (div0) begin
            quo_q <= '1;
            rem_q <= cmd_a;
            state <= S_DONE;
          end else if (ovf) begin
            quo_q <= cmd_a;
            rem_q <= '0;
            state <= S_DONE;
          end else if (int'(zblk) == NBLK) begin
            quo_q <= '0;
            rem_q <= '0;
            state <= S_DONE;
          end else begin
            quo_q  <= mag_a << (int'(zblk) * BLK);
            rem_q  <= '0;
            cnt_q  <= CW'((NBLK - int'(zblk)) * CPB);
            negq_q <= a_neg ^ b_neg;
            negr_q <= a_neg;
            state  <= S_RUN;
          end
        end
        S_RUN: begin
          quo_q <= {quo_q[XLEN-3:0], s1[XLEN], s2[XLEN]};
          rem_q <= s2[XLEN-1:0];
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CW'(1)) state <= S_DONE;
        end
        S_DONE: if (res_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  wire [XLEN-1:0] quo_f = negq_q ? -quo_q : quo_q;
  wire [XLEN-1:0] rem_f = negr_q ? -rem_q : rem_q;
  assign res_data = sel_q ? rem_f : quo_f;

  AST_DIV0_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    accept && div0 |=> res_valid &&
      res_data == ($past(cmd_rem) ? $past(cmd_a) : {XLEN{1'b1}})); // R3
  AST_OVF_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    accept && ovf |=> res_valid &&
      res_data == ($past(cmd_rem) ? '0 : $past(cmd_a))); // R4
  AST_FULL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !div0 && !ovf && mag_a[XLEN-1 -: BLK] != '0 |=> busy && !res_valid); // R5
  AST_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !cmd_ready); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data)); // R7
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> !res_valid && cmd_ready); // R7
endmodule

// File: tb/tb_radix4_divider.sv
`timescale 1ns/1ps
module tb_radix4_divider;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_signed = 1'b0, cmd_rem = 1'b0, res_ready = 1'b0;
  logic [31:0] cmd_a = '0, cmd_b = '0;
  logic cmd_ready, res_valid, busy;
  logic [31:0] res_data;

  radix4_divider #(.XLEN(32)) dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errs = 0;
  bit finished = 0;

  typedef struct { logic [31:0] data; int lat; int stall; string tag; } exp_t;
  exp_t sbq[$];

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] a, b, input logic sg, rm);
    if (b == 0) return rm ? a : 32'hFFFF_FFFF;
    if (sg && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return rm ? 32'h0 : a;
    if (sg) return rm ? 32'($signed(a) % $signed(b)) : 32'($signed(a) / $signed(b));
    return rm ? a % b : a / b;
  endfunction

  function automatic int lat_model(input logic [31:0] a, b, input logic sg);
    logic [31:0] m;
    int z;
    if (b == 0) return 1;
    if (sg && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 1;
    m = (sg && a[31]) ? -a : a;
    z = 0;
    for (int i = 3; i >= 0; i--) begin
      if (m[i*8 +: 8] != 0) break;
      z++;
    end
    return (z == 4) ? 1 : 1 + 4 * (4 - z);
  endfunction

  task automatic op(input logic [31:0] a, b, input logic sg, rm, input int stall,
                    input string tag, input bit poke);
    exp_t e;
    e.data = model(a, b, sg, rm);
    e.lat = lat_model(a, b, sg);
    e.stall = stall;
    e.tag = tag;
    sbq.push_back(e);
    do begin @(posedge clk); #1; end while (!cmd_ready);
    cmd_a = a; cmd_b = b; cmd_signed = sg; cmd_rem = rm; cmd_valid = 1'b1;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    if (poke) begin
      cmd_a = ~a; cmd_b = 32'h3; cmd_rem = ~rm; cmd_valid = 1'b1;
      repeat (2) @(posedge clk);
      #1 cmd_valid = 1'b0;
    end
    wait (sbq.size() == 0);
  endtask

  initial begin : monitor
    bit counting = 0, got = 0, relchk = 0;
    int edges = 0, stall = 0;
    logic [31:0] held = '0;
    exp_t e;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      res_ready = 1'b0;
      if (relchk) begin
        chk(!res_valid && cmd_ready, "R7 release", {30'b0, res_valid, cmd_ready}, 32'h1);
        relchk = 0;
      end
      if (cmd_valid && cmd_ready) begin
        counting = 1; edges = 0;
      end else if (counting) begin
        edges++;
        if (res_valid) begin
          e = sbq[0];
          chk(res_data === e.data, {e.tag, " data"}, res_data, e.data);
          chk(edges == e.lat, {e.tag, " latency R5"}, edges, e.lat);
          counting = 0; got = 1; held = res_data; stall = e.stall;
        end
      end else if (got) begin
        chk(res_valid && res_data === held, "R7 hold", res_data, held);
        chk(!cmd_ready && busy, "R6 not ready while holding", {30'b0, cmd_ready, busy}, 32'h1);
      end
      if (got) begin
        if (stall == 0) begin
          res_ready = 1'b1;
          void'(sbq.pop_front());
          got = 0; relchk = 1;
        end else stall--;
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(cmd_ready && !res_valid && !busy, "R8 reset", {29'b0, cmd_ready, res_valid, busy}, 32'h4);
    rst_n = 1'b1;
    op(32'd100, 32'd7, 0, 0, 0, "R1 udiv", 0);
    op(32'd100, 32'd7, 0, 1, 2, "R1 R9 urem", 0);
    op(32'hFFFF_FFFF, 32'd3, 0, 0, 3, "R1 full udiv", 1);
    op(32'h0123_4567, 32'h10, 0, 1, 0, "R1 R9 urem", 1);
    op(32'h00FF_0000, 32'h100, 0, 0, 1, "R1 R5 skip1", 0);
    op(32'h0000_8001, 32'h3, 0, 0, 0, "R5 skip2", 0);
    op(-32'sd7, 32'd2, 1, 0, 0, "R2 sdiv", 0);
    op(-32'sd7, 32'd2, 1, 1, 1, "R2 srem", 0);
    op(32'd7, -32'sd2, 1, 1, 0, "R2 srem pos", 0);
    op(-32'sd100, -32'sd7, 1, 0, 0, "R2 sdiv negneg", 0);
    op(32'h8000_0000, 32'd2, 1, 0, 0, "R2 min by 2", 1);
    op(32'h8000_0000, 32'd1, 1, 1, 0, "R2 min rem 1", 0);
    op(32'h0000_0011, 32'd0, 0, 0, 2, "R3 div0 q", 0);
    op(32'h0000_0011, 32'd0, 0, 1, 0, "R3 div0 r", 0);
    op(32'hF000_0001, 32'd0, 1, 1, 0, "R3 div0 signed r", 0);
    op(32'h8000_0000, 32'hFFFF_FFFF, 1, 0, 1, "R4 ovf q", 0);
    op(32'h8000_0000, 32'hFFFF_FFFF, 1, 1, 0, "R4 ovf r", 0);
    op(32'h8000_0000, 32'hFFFF_FFFF, 0, 0, 0, "R1 unsigned no ovf", 0);
    op(32'd0, 32'd5, 0, 0, 0, "R5 zero dividend", 0);
    op(32'd5, 32'hFFFF_FFF0, 0, 1, 0, "R1 small over large", 0);
    op(32'h1234_5678, 32'h0000_0123, 0, 0, 4, "R6 poke ignored", 1);
    repeat (3) @(posedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule